// File: doc/BRIEF.md
# Mode-Gated Debounced Panel Switches

This block sits between three front-panel pushbuttons (start, stop and reset) and the control logic of a larger system. Each raw button level is brought into the clock domain by a two-stage synchroniser, then filtered by a debouncer. The debouncer accepts a new level only after the synchronised input has held that level for a set number of consecutive clocks. A press that survives the filter produces a single one-clock pulse on its rising edge.

A two-bit mode selector chooses which buttons are allowed through. In manual mode all three buttons are live. In set mode start and reset are live and stop is held off. In continuous and program modes all three are held off. One indicator output per button shows whether that button is live in the current mode, so a lamp driver can show the operator which buttons will respond.

The enable for a button is sampled when its filtered level rises. A button that is already held when its mode becomes enabling therefore does nothing until it is released and pressed again.

Top module: `panel_key_gate`

## Requirements
- R1: A change of a raw button level is taken into the debounced state only after the synchronised input has differed from that state for DEBOUNCE_CYCLES consecutive clocks. An excursion shorter than that produces no pulse.
- R2: Each accepted press gives exactly one pulse, one clock wide, on the matching pulse output.
- R3: Releasing a button, bounces included, gives no pulse.
- R4: With mode code 2'b00 (manual), presses of start, stop and reset each give their pulse.
- R5: With mode code 2'b01 (set), start and reset give pulses and stop gives none.
- R6: With mode code 2'b10 (continuous) or 2'b11 (program), no button gives a pulse.
- R7: Each lamp output is high exactly when its button is enabled by the current mode code.
- R8: A button is gated by the mode in force when its debounced level rises. A button held while the mode changes to an enabling one gives no pulse.
- R9: While reset is asserted and after its release, all pulse outputs are low and the debounced state of every button is released (low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_start | input | 1 | Raw start button level, high when pressed |
| raw_stop | input | 1 | Raw stop button level, high when pressed |
| raw_reset | input | 1 | Raw reset button level, high when pressed |
| mode | input | 2 | Mode code: 00 manual, 01 set, 10 continuous, 11 program |
| start_pulse | output | 1 | One-clock pulse for an accepted, enabled start press |
| stop_pulse | output | 1 | One-clock pulse for an accepted, enabled stop press |
| reset_pulse | output | 1 | One-clock pulse for an accepted, enabled reset press |
| start_lamp | output | 1 | High while start is enabled by the mode |
| stop_lamp | output | 1 | High while stop is enabled by the mode |
| reset_lamp | output | 1 | High while reset is enabled by the mode |

## Verification
The bench drives presses wrapped in bursts of bounce, shorter than the filter window, on both the press and the release. A debouncer that counts total rather than consecutive samples, or that fires on the falling edge, would emit extra or early pulses there. Every mode code is exercised against all three buttons. A stop pulse leaking through in set mode, or any pulse in continuous or program mode, is reported as unexpected. A button held across a change from continuous to manual checks that the enable is taken at the edge; a design that gates a level rather than an edge would fire late at that point. Lamps are compared with the enable table for every mode code.

// File: rtl/panel_key_pkg.sv
// Package: shared types and the mode-to-enable table for the panel switch gate.
// Assumes three buttons in fixed index order: start, stop, reset.
package panel_key_pkg;

    localparam int KEY_COUNT = 3;
    localparam int KEY_START = 0;
    localparam int KEY_STOP  = 1;
    localparam int KEY_RESET = 2;

    typedef enum logic [1:0] {
        MODE_MANUAL = 2'b00,
        MODE_SET    = 2'b01,
        MODE_CONT   = 2'b10,
        MODE_PROG   = 2'b11
    } panel_mode_e;

    // Enable vector for one mode; bit index follows the KEY_* order.
    function automatic logic [KEY_COUNT-1:0] key_enables(panel_mode_e m);
        logic [KEY_COUNT-1:0] en;
        en = '0;
        case (m)
            MODE_MANUAL: begin
                en[KEY_START] = 1'b1;
                en[KEY_STOP]  = 1'b1;
                en[KEY_RESET] = 1'b1;
            end
            MODE_SET: begin
                en[KEY_START] = 1'b1;
                en[KEY_RESET] = 1'b1;
            end
            default: en = '0;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/key_sync.sv
// Module: key_sync
// Brings one asynchronous button level into the clock domain through a
// chain of STAGES flops. Assumes the input is a slow level, not a pulse.
module key_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/key_debounce.sv
// Module: key_debounce
// Holds a filtered level for one synchronised button. The level changes only
// after the input has differed from it for STABLE_CYCLES consecutive clocks.
// Any return to the held level restarts the count. Assumes STABLE_CYCLES >= 1.
module key_debounce #(
    parameter int STABLE_CYCLES = 800_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic level
);
    localparam int CNT_W = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);

    logic [CNT_W-1:0] run_cnt;

    // Count consecutive differing samples and adopt the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= 1'b0;
            run_cnt <= '0;
        end else if (sync_in == level) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            level   <= sync_in;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mode_enable_decode.sv
// Module: mode_enable_decode
// Turns the two-bit mode code into one enable bit per button, in KEY_* order.
// Purely combinational; assumes the mode code is already synchronous.
module mode_enable_decode
    import panel_key_pkg::*;
(
    input  logic [1:0]           mode_code,
    output logic [KEY_COUNT-1:0] key_en
);
    // Look up the enable vector for the current mode.
    always_comb begin
        key_en = key_enables(panel_mode_e'(mode_code));
    end
endmodule

// File: rtl/panel_key_gate.sv
// Module: panel_key_gate (top)
// Synchronises and debounces three panel buttons. It emits a one-clock pulse
// on each debounced rising edge when the current mode enables that button,
// and drives one lamp per button showing its enable.
// Assumes a synchronous active-low reset and a mode code synchronous to clk.
module panel_key_gate
    import panel_key_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 800_000   // 16 ms at 50 MHz
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_start,
    input  logic       raw_stop,
    input  logic       raw_reset,
    input  logic [1:0] mode,
    output logic       start_pulse,
    output logic       stop_pulse,
    output logic       reset_pulse,
    output logic       start_lamp,
    output logic       stop_lamp,
    output logic       reset_lamp
);
    logic [KEY_COUNT-1:0] raw_vec;
    logic [KEY_COUNT-1:0] sync_vec;
    logic [KEY_COUNT-1:0] clean_vec;
    logic [KEY_COUNT-1:0] clean_prev;
    logic [KEY_COUNT-1:0] pulse_vec;
    logic [KEY_COUNT-1:0] en_vec;

    assign raw_vec[KEY_START] = raw_start;
    assign raw_vec[KEY_STOP]  = raw_stop;
    assign raw_vec[KEY_RESET] = raw_reset;

    mode_enable_decode u_decode (
        .mode_code (mode),
        .key_en    (en_vec)
    );

    for (genvar k = 0; k < KEY_COUNT; k++) begin : g_key
        key_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_vec[k]),
            .sync_out (sync_vec[k])
        );

        key_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (sync_vec[k]),
            .level   (clean_vec[k])
        );

        // Detect the debounced rising edge and gate it with the live enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                clean_prev[k] <= 1'b0;
                pulse_vec[k]  <= 1'b0;
            end else begin
                clean_prev[k] <= clean_vec[k];
                pulse_vec[k]  <= clean_vec[k] & ~clean_prev[k] & en_vec[k];
            end
        end
    end

    assign start_pulse = pulse_vec[KEY_START];
    assign stop_pulse  = pulse_vec[KEY_STOP];
    assign reset_pulse = pulse_vec[KEY_RESET];

    assign start_lamp  = en_vec[KEY_START];
    assign stop_lamp   = en_vec[KEY_STOP];
    assign reset_lamp  = en_vec[KEY_RESET];
endmodule

// File: rtl/panel_key_gate_chk.sv
// Module: panel_key_gate_chk
// Property checker for panel_key_gate, attached through bind below.
module panel_key_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       start_pulse,
    input logic       stop_pulse,
    input logic       reset_pulse,
    input logic       start_lamp,
    input logic       stop_lamp,
    input logic       reset_lamp
);
    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    // R2
    stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);
    // R2
    reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> !reset_pulse);
    // R5
    set_stop_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b01) |-> !stop_pulse);
    // R6
    auto_modes_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode[1]) |-> !(start_pulse || stop_pulse || reset_pulse));
    // R7
    lamp_table_chk: assert property (@(posedge clk)
        (start_lamp == !mode[1]) && (reset_lamp == !mode[1]) &&
        (stop_lamp == (mode == 2'b00)));
    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !(start_pulse || stop_pulse || reset_pulse));
endmodule

bind panel_key_gate panel_key_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .reset_pulse (reset_pulse),
    .start_lamp  (start_lamp),
    .stop_lamp   (stop_lamp),
    .reset_lamp  (reset_lamp)
);

// File: tb/panel_key_gate_tb.sv
// Scoreboard bench: the driver pushes the key index it expects to fire,
// and the monitor pops and compares on every observed pulse.
module panel_key_gate_tb;
    localparam int DEB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] raw = 3'b000;          // [0] start, [1] stop, [2] reset
    logic [1:0] mode = 2'b00;
    logic       start_pulse, stop_pulse, reset_pulse;
    logic       start_lamp, stop_lamp, reset_lamp;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic [2:0] prev_p = 3'b000;
    bit done = 0;

    always #10 clk = ~clk;             // 50 MHz

    panel_key_gate #(.SYNC_STAGES(2), .DEBOUNCE_CYCLES(DEB)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .raw_start(raw[0]), .raw_stop(raw[1]), .raw_reset(raw[2]),
        .mode(mode),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .reset_pulse(reset_pulse),
        .start_lamp(start_lamp), .stop_lamp(stop_lamp), .reset_lamp(reset_lamp)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: compare each pulse against the scoreboard, and check its width.
    always @(negedge clk) begin
        logic [2:0] p;
        p = {reset_pulse, stop_pulse, start_pulse};
        if (rst_n) begin
            for (int k = 0; k < 3; k++) begin
                if (p[k]) begin
                    if (prev_p[k]) check(0, "R2 pulse wider than one clock", k, -1);
                    if (exp_q.size() == 0) begin
                        check(0, "R1/R3/R5/R6/R8 unexpected pulse", k, -1);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        check(e == k, "R2 pulse key index", k, e);
                    end
                end
            end
        end
        prev_p = p;
    end

    task automatic bounce(input int k, input bit lvl);
        for (int i = 0; i < 3; i++) begin
            raw[k] = lvl;  repeat (DEB - 3) @(posedge clk);
            raw[k] = !lvl; repeat (2) @(posedge clk);
        end
        raw[k] = lvl;
    endtask

    // Driver: a bouncy press and release; expect one pulse if enabled.
    task automatic press(input int k, input bit expect_pulse, input string req);
        if (expect_pulse) exp_q.push_back(k);
        bounce(k, 1'b1);
        repeat (DEB + 10) @(posedge clk);
        bounce(k, 1'b0);               // R3: release bounce must stay silent
        repeat (DEB + 10) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic lamps(input logic [1:0] m, input logic [2:0] exp);
        mode = m;
        @(negedge clk);
        check({reset_lamp, stop_lamp, start_lamp} == exp, "R7 lamps",
              {reset_lamp, stop_lamp, start_lamp}, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check({reset_pulse, stop_pulse, start_pulse} == 3'b000, "R9 pulses in reset",
              {reset_pulse, stop_pulse, start_pulse}, 0);
        raw = 3'b111;                  // held during reset: must not leak
        repeat (4) @(posedge clk);
        raw = 3'b000;
        rst_n = 1'b1;
        repeat (DEB + 6) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R9 quiet after reset", exp_q.size(), 0);

        lamps(2'b00, 3'b111);
        lamps(2'b01, 3'b101);
        lamps(2'b10, 3'b000);
        lamps(2'b11, 3'b000);

        // R1: glitches shorter than the window
        mode = 2'b00;
        for (int i = 0; i < 4; i++) begin
            raw[0] = 1'b1; repeat (DEB - 1) @(posedge clk);
            raw[0] = 1'b0; repeat (3) @(posedge clk);
        end
        repeat (DEB + 6) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R1 short glitches", exp_q.size(), 0);

        mode = 2'b00;                  // R4
        press(0, 1, "R4 manual start");
        press(1, 1, "R4 manual stop");
        press(2, 1, "R4 manual reset");
        mode = 2'b01;                  // R5
        press(0, 1, "R5 set start");
        press(1, 0, "R5 set stop blocked");
        press(2, 1, "R5 set reset");
        mode = 2'b10;                  // R6
        press(0, 0, "R6 continuous start");
        press(1, 0, "R6 continuous stop");
        press(2, 0, "R6 continuous reset");
        mode = 2'b11;
        press(0, 0, "R6 program start");
        press(1, 0, "R6 program stop");
        press(2, 0, "R6 program reset");

        // R8: held across a change to an enabling mode
        mode = 2'b10;
        raw[2] = 1'b1;
        repeat (DEB + 10) @(posedge clk);
        mode = 2'b00;
        repeat (DEB + 10) @(posedge clk);
        raw[2] = 1'b0;
        repeat (DEB + 10) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R8 held across mode change", exp_q.size(), 0);
        press(2, 1, "R8 fresh press after mode change");

        done = 1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog expired", 0, 1);
            summary();
        end
    end
endmodule